// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block runs an analog-to-digital converter over a contiguous range of channels. Software programs a first and a last channel index, picks a mode and a completion route, then sets a start bit. The controller issues a one-cycle convert strobe with a channel number, waits for the converter's done pulse, and stores the returned sample in that channel's result register. It then moves to the next higher channel. The converter itself is outside the block and answers after a latency of its own.

The start bit also serves as the busy flag. In the single-pass modes the hardware clears it when the last channel of the range has been stored. In scan mode the range repeats until software clears the bit or a standby request arrives. Each completed pass either sets a sticky interrupt flag or raises a DMA request that stays up until it is acknowledged. A pass that is cut short gives neither. A conversion can also be started by a rising edge on an external trigger pin, when the trigger-enable code allows it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `irq`, `dma_req` and `conv_start` are low.
- R2: Writing control (address 0) with bit 0 set and mode bits [2:1] at 00 (single) or 01 (multi) starts a pass. Code 11 acts as single. Bit 0 reads 1 until the pass ends, then hardware clears it. Channels first..last (range register at address 2: first in bits [2:0], last in bits [10:8]) are each converted once in ascending order. Each result is readable at address 8+channel. Channels outside the range keep their values.
- R3: With mode 10 (scan), passes over the range repeat without end. Bit 0 stays 1, and each completed pass signals completion.
- R4: Writing 0 to control bit 0 while a pass runs lets the in-flight conversion finish and store its result. It then stops: no further convert strobe, and no interrupt or DMA request for that pass.
- R5: A cycle of `standby_req` clears control bit 0 on the next edge and stops the sequence as in R4.
- R6: With control bit 3 at 0, a completed pass sets `irq` and status bit 0 (address 1). The flag holds until software writes 1 to status bit 0.
- R7: With control bit 3 at 1, a completed pass raises `dma_req` instead of `irq` (status bit 1). The request holds until `dma_ack` is high. Control bit 3 always reads as 0.
- R8: With trigger-enable bits [5:4] at 11, a rising edge on `trg_in` (seen after a two-flop synchronizer) starts a pass as if bit 0 had been written. Codes 00, 01 and 10 give no start.
- R9: A trigger edge that arrives while a pass is running is ignored, and no second pass follows.
- R10: Undefined bits read as 0, and writes to them have no effect. After writing all ones, control reads 0x0037 and range reads 0x0707.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | ADDR_W | Register address |
| cpu_wdata | input | REG_W | Write data |
| cpu_rdata | output | REG_W | Read data for `cpu_addr` (combinational) |
| trg_in | input | 1 | External trigger, asynchronous |
| standby_req | input | 1 | Standby request, stops any sequence |
| conv_start | output | 1 | One-cycle convert strobe to the converter |
| conv_ch | output | CH_W | Channel for the current conversion |
| conv_done | input | 1 | One-cycle done pulse from the converter |
| conv_data | input | DATA_W | Sample, valid with `conv_done` |
| irq | output | 1 | Sticky end-of-pass interrupt |
| dma_req | output | 1 | End-of-pass DMA request |
| dma_ack | input | 1 | DMA acknowledge, clears `dma_req` |

## Verification
The bench builds the block with eight channels, 10-bit samples, a 4-bit address and a two-stage trigger synchronizer. It drives a converter model that answers four cycles after each strobe with a sample computed from the channel and a per-test seed. Eight channels make a run from the top index 7 back down, a single-channel range and a full 0..7 range all cheap to reach. After every pass the bench reads all eight result registers, so a write to a channel outside the range shows up. The four-cycle latency leaves a window to clear the start bit, raise standby or pulse the trigger while a conversion is in flight.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_MULTI  = 2'b01,
    MODE_SCAN   = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_LAUNCH = 2'b01,
    ST_WAIT   = 2'b10
  } seq_st_e;

  localparam int ADR_CTRL  = 0;
  localparam int ADR_STAT  = 1;
  localparam int ADR_RANGE = 2;

  localparam int CTL_GO      = 0;
  localparam int CTL_MODE_LO = 1;
  localparam int CTL_ROUTE   = 3;
  localparam int CTL_TRG_LO  = 4;

  localparam int STA_IRQ = 0;
  localparam int STA_DMA = 1;

  localparam int RNG_LAST_LO = 8;

  localparam logic [1:0] TRG_ON = 2'b11;

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trg_in,
  output logic trg_rise
);

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], trg_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign trg_rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [1:0]      mode,
  input  logic [CH_W-1:0] first_ch,
  input  logic [CH_W-1:0] last_ch,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CH_W-1:0] cur_ch,
  output logic            res_we,
  output logic            pass_done,
  output logic            hw_clr,
  output logic            busy
);

  seq_st_e         st_q, st_d;
  logic [CH_W-1:0] cur_q, cur_d;
  logic            abort_q, abort_d;
  logic            at_end;
  logic            is_scan;

  assign at_end  = (cur_q == last_ch) || (int'(cur_q) == NUM_CH - 1);
  assign is_scan = (mode == MODE_SCAN);

  always_comb begin
    st_d       = st_q;
    cur_d      = cur_q;
    abort_d    = abort_q;
    conv_start = 1'b0;
    res_we     = 1'b0;
    pass_done  = 1'b0;
    hw_clr     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        abort_d = 1'b0;
        if (go) begin
          cur_d = first_ch;
          st_d  = ST_LAUNCH;
        end
      end
      ST_LAUNCH: begin
        if (!go) begin
          st_d = ST_IDLE;
        end else begin
          conv_start = 1'b1;
          st_d       = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!go) abort_d = 1'b1;
        if (conv_done) begin
          res_we = 1'b1;
          if (!go || abort_q) begin
            st_d = ST_IDLE;
          end else if (at_end) begin
            pass_done = 1'b1;
            if (is_scan) begin
              cur_d = first_ch;
              st_d  = ST_LAUNCH;
            end else begin
              hw_clr = 1'b1;
              st_d   = ST_IDLE;
            end
          end else begin
            cur_d = cur_q + 1'b1;
            st_d  = ST_LAUNCH;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      abort_q <= abort_d;
    end
  end

  assign cur_ch = cur_q;
  assign busy   = (st_q != ST_IDLE);

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3,
  parameter int DATA_W = 10,
  parameter int ADDR_W = 4,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  logic              standby_req,
  input  logic              trg_start,
  input  logic              hw_clr,
  input  logic              res_we,
  input  logic [CH_W-1:0]   res_ch,
  input  logic [DATA_W-1:0] res_data,
  input  logic              pass_done,
  input  logic              dma_ack,
  output logic              go,
  output logic [1:0]        mode,
  output logic [1:0]        trg_en,
  output logic [CH_W-1:0]   first_ch,
  output logic [CH_W-1:0]   last_ch,
  output logic              irq,
  output logic              dma_req
);

  logic ctrl_wr, stat_wr, rng_wr, data_sel;
  logic [CH_W-1:0] rd_idx;

  logic            go_q, go_d;
  logic [1:0]      mode_q, mode_d;
  logic            route_q, route_d;
  logic [1:0]      trg_q, trg_d;
  logic [CH_W-1:0] first_q, first_d, last_q, last_d;
  logic            irq_q, irq_d, dma_q, dma_d;
  logic [DATA_W-1:0] res_q [NUM_CH];

  assign ctrl_wr  = cpu_we && (cpu_addr == ADDR_W'(ADR_CTRL));
  assign stat_wr  = cpu_we && (cpu_addr == ADDR_W'(ADR_STAT));
  assign rng_wr   = cpu_we && (cpu_addr == ADDR_W'(ADR_RANGE));
  assign data_sel = cpu_addr[ADDR_W-1];
  assign rd_idx   = cpu_addr[CH_W-1:0];

  always_comb begin
    go_d    = go_q;
    mode_d  = mode_q;
    route_d = route_q;
    trg_d   = trg_q;
    if (hw_clr)    go_d = 1'b0;
    if (trg_start) go_d = 1'b1;
    if (ctrl_wr) begin
      go_d    = cpu_wdata[CTL_GO];
      mode_d  = cpu_wdata[CTL_MODE_LO +: 2];
      route_d = cpu_wdata[CTL_ROUTE];
      trg_d   = cpu_wdata[CTL_TRG_LO +: 2];
    end
    if (standby_req) go_d = 1'b0;
  end

  always_comb begin
    first_d = first_q;
    last_d  = last_q;
    if (rng_wr) begin
      first_d = cpu_wdata[CH_W-1:0];
      last_d  = cpu_wdata[RNG_LAST_LO +: CH_W];
    end
  end

  always_comb begin
    irq_d = irq_q;
    dma_d = dma_q;
    if (stat_wr && cpu_wdata[STA_IRQ]) irq_d = 1'b0;
    if (pass_done && !route_q)         irq_d = 1'b1;
    if (dma_ack)                       dma_d = 1'b0;
    if (pass_done && route_q)          dma_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      mode_q  <= 2'b00;
      route_q <= 1'b0;
      trg_q   <= 2'b00;
      first_q <= '0;
      last_q  <= '0;
      irq_q   <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      go_q    <= go_d;
      mode_q  <= mode_d;
      route_q <= route_d;
      trg_q   <= trg_d;
      first_q <= first_d;
      last_q  <= last_d;
      irq_q   <= irq_d;
      dma_q   <= dma_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_res
    logic wr_en;
    assign wr_en = res_we && (int'(res_ch) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     res_q[g] <= '0;
      else if (wr_en) res_q[g] <= res_data;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (data_sel) begin
      if (int'(rd_idx) < NUM_CH) cpu_rdata[DATA_W-1:0] = res_q[rd_idx];
    end else begin
      unique case (int'(cpu_addr))
        ADR_CTRL: begin
          cpu_rdata[CTL_GO]          = go_q;
          cpu_rdata[CTL_MODE_LO +: 2] = mode_q;
          cpu_rdata[CTL_TRG_LO +: 2]  = trg_q;
        end
        ADR_STAT: begin
          cpu_rdata[STA_IRQ] = irq_q;
          cpu_rdata[STA_DMA] = dma_q;
        end
        ADR_RANGE: begin
          cpu_rdata[CH_W-1:0]           = first_q;
          cpu_rdata[RNG_LAST_LO +: CH_W] = last_q;
        end
        default: cpu_rdata = '0;
      endcase
    end
  end

  assign go       = go_q;
  assign mode     = mode_q;
  assign trg_en   = trg_q;
  assign first_ch = first_q;
  assign last_ch  = last_q;
  assign irq      = irq_q;
  assign dma_req  = dma_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int DATA_W      = 10,
  parameter int ADDR_W      = 4,
  parameter int REG_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  logic              trg_in,
  input  logic              standby_req,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              irq,
  output logic              dma_req,
  input  logic              dma_ack
);

  logic [1:0]      rst_sync_q;
  logic            rst_sn;
  logic            go_w, fsm_busy_w, hw_clr_w, res_we_w, pass_done_w;
  logic            trg_rise_w, trg_start_w;
  logic [1:0]      mode_w, trg_en_w;
  logic [CH_W-1:0] first_w, last_w, cur_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  adc_seq_trig #(.STAGES(SYNC_STAGES)) trig_i (
    .clk      (clk),
    .rst_n    (rst_sn),
    .trg_in   (trg_in),
    .trg_rise (trg_rise_w)
  );

  assign trg_start_w = trg_rise_w && (trg_en_w == TRG_ON) && !go_w && !fsm_busy_w;

  adc_seq_regs #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
  ) regs_i (
    .clk         (clk),
    .rst_n       (rst_sn),
    .cpu_we      (cpu_we),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .cpu_rdata   (cpu_rdata),
    .standby_req (standby_req),
    .trg_start   (trg_start_w),
    .hw_clr      (hw_clr_w),
    .res_we      (res_we_w),
    .res_ch      (cur_w),
    .res_data    (conv_data),
    .pass_done   (pass_done_w),
    .dma_ack     (dma_ack),
    .go          (go_w),
    .mode        (mode_w),
    .trg_en      (trg_en_w),
    .first_ch    (first_w),
    .last_ch     (last_w),
    .irq         (irq),
    .dma_req     (dma_req)
  );

  adc_seq_fsm #(.NUM_CH(NUM_CH), .CH_W(CH_W)) fsm_i (
    .clk        (clk),
    .rst_n      (rst_sn),
    .go         (go_w),
    .mode       (mode_w),
    .first_ch   (first_w),
    .last_ch    (last_w),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .cur_ch     (cur_w),
    .res_we     (res_we_w),
    .pass_done  (pass_done_w),
    .hw_clr     (hw_clr_w),
    .busy       (fsm_busy_w)
  );

  assign conv_ch = cur_w;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int ADDR_W = 4,
  parameter int REG_W  = 16,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [REG_W-1:0]  cpu_wdata,
  input logic [REG_W-1:0]  cpu_rdata,
  input logic              standby_req,
  input logic              conv_start,
  input logic [CH_W-1:0]   conv_ch,
  input logic              irq,
  input logic              dma_req,
  input logic              dma_ack,
  input logic              go,
  input logic              fsm_busy,
  input logic [CH_W-1:0]   first_ch,
  input logic [CH_W-1:0]   last_ch
);

  logic irq_clr;
  assign irq_clr = cpu_we && (cpu_addr == ADDR_W'(1)) && cpu_wdata[0];

  // R2: every strobe addresses a channel inside the programmed range
  a_r2_ch_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_ch >= first_ch) && (conv_ch <= last_ch));

  // R2: the convert strobe lasts a single cycle
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R4: with the start bit low and the sequencer idle, no strobe
  a_r4_no_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !fsm_busy) |-> !conv_start);

  // R5: standby clears the start bit on the next edge
  a_r5_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
    standby_req |=> !go);

  // R6: the interrupt flag holds until cleared by software
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R7: the DMA request holds until acknowledged
  a_r7_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> dma_req);

  // R7: route bit is never visible in the control readback
  a_r7_route_reads0: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr == ADDR_W'(0)) |-> (cpu_rdata[3] == 1'b0));

endmodule

bind adc_seq_ctrl adc_seq_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W), .CH_W(CH_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_sn),
  .cpu_we      (cpu_we),
  .cpu_addr    (cpu_addr),
  .cpu_wdata   (cpu_wdata),
  .cpu_rdata   (cpu_rdata),
  .standby_req (standby_req),
  .conv_start  (conv_start),
  .conv_ch     (conv_ch),
  .irq         (irq),
  .dma_req     (dma_req),
  .dma_ack     (dma_ack),
  .go          (go_w),
  .fsm_busy    (fsm_busy_w),
  .first_ch    (first_w),
  .last_ch     (last_w)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;

  localparam int NUM_CH = 8;
  localparam int DATA_W = 10;
  localparam int ADDR_W = 4;
  localparam int REG_W  = 16;
  localparam int CH_W   = 3;
  localparam int LAT    = 4;

  // {mode[1:0], route, first[2:0], last[2:0]}
  localparam logic [8:0] VEC [6] = '{
    {2'b00, 1'b0, 3'd0, 3'd3},
    {2'b01, 1'b1, 3'd2, 3'd5},
    {2'b00, 1'b1, 3'd7, 3'd7},
    {2'b01, 1'b0, 3'd0, 3'd7},
    {2'b11, 1'b0, 3'd4, 3'd6},
    {2'b00, 1'b0, 3'd3, 3'd3}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_we;
  logic [ADDR_W-1:0] cpu_addr;
  logic [REG_W-1:0]  cpu_wdata, cpu_rdata;
  logic trg_in, standby_req;
  logic conv_start;
  logic [CH_W-1:0] conv_ch;
  logic conv_done;
  logic [DATA_W-1:0] conv_data;
  logic irq, dma_req, dma_ack;

  int n_chk = 0;
  int n_err = 0;
  int start_cnt = 0;
  int seed = 0;
  int cnt = 0;
  logic [CH_W-1:0] ch_lat;
  logic [DATA_W-1:0] exp_mem [NUM_CH];
  bit finished = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .trg_in(trg_in), .standby_req(standby_req),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data),
    .irq(irq), .dma_req(dma_req), .dma_ack(dma_ack)
  );

  function automatic logic [DATA_W-1:0] sample(input int ch, input int sd);
    return DATA_W'((ch * 29 + sd * 7 + 5) % 1024);
  endfunction

  // converter model: done pulse LAT cycles after each strobe
  always @(posedge clk) begin
    if (!rst_n) begin
      conv_done <= 1'b0;
      conv_data <= '0;
      cnt <= 0;
    end else begin
      conv_done <= 1'b0;
      if (conv_start) start_cnt <= start_cnt + 1;
      if (cnt > 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin
          conv_done <= 1'b1;
          conv_data <= sample(int'(ch_lat), seed);
        end
      end else if (conv_start) begin
        cnt <= LAT;
        ch_lat <= conv_ch;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [REG_W-1:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = ADDR_W'(a); cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0; cpu_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [REG_W-1:0] d);
    @(negedge clk);
    cpu_addr = ADDR_W'(a);
    #1 d = cpu_rdata;
  endtask

  task automatic wait_go_low();
    logic [REG_W-1:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(0, v);
      if (!v[0]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_trg();
    @(negedge clk); trg_in = 1'b1;
    repeat (4) @(negedge clk);
    trg_in = 1'b0;
  endtask

  task automatic check_data(input string req);
    logic [REG_W-1:0] v;
    for (int c = 0; c < NUM_CH; c++) begin
      rd(8 + c, v);
      chk(req, 32'(v), 32'(exp_mem[c]));
    end
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [REG_W-1:0] v;
    int base;
    rst_n = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    trg_in = 1'b0; standby_req = 1'b0; dma_ack = 1'b0;
    for (int c = 0; c < NUM_CH; c++) exp_mem[c] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 ctrl", 32'(v), 0);
    rd(1, v); chk("R1 status", 32'(v), 0);
    rd(2, v); chk("R1 range", 32'(v), 0);
    rd(8, v); chk("R1 data0", 32'(v), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 dma_req", 32'(dma_req), 0);
    chk("R1 conv_start", 32'(conv_start), 0);

    // R2 R6 R7 vector walk
    for (int i = 0; i < 6; i++) begin
      logic [1:0] md; logic rt; int f; int l;
      {md, rt} = VEC[i][8:6];
      f = int'(VEC[i][5:3]); l = int'(VEC[i][2:0]);
      seed = i + 1;
      wr(2, REG_W'((l << 8) | f));
      base = start_cnt;
      wr(0, REG_W'({rt, md, 1'b1}));
      rd(0, v); chk("R2 busy reads 1", 32'(v[0]), 1);
      wait_go_low();
      for (int c = f; c <= l; c++) exp_mem[c] = sample(c, seed);
      check_data("R2 result");
      chk("R2 strobe count", 32'(start_cnt - base), 32'(l - f + 1));
      rd(1, v);
      if (!rt) begin
        chk("R6 status irq", 32'(v), 1);
        chk("R6 irq pin", 32'(irq), 1);
        wr(1, 16'h0001);
        chk("R6 irq cleared", 32'(irq), 0);
      end else begin
        chk("R7 status dma", 32'(v), 2);
        chk("R7 irq stays low", 32'(irq), 0);
        repeat (3) @(negedge clk);
        chk("R7 dma held", 32'(dma_req), 1);
        dma_ack = 1'b1; @(negedge clk); dma_ack = 1'b0;
        chk("R7 dma cleared", 32'(dma_req), 0);
      end
    end

    // R10 R7 reserved bits and route readback
    seed = 20;
    wr(2, 16'hFFFF);
    rd(2, v); chk("R10 range readback", 32'(v), 32'h0707);
    wr(0, 16'hFFFF);
    rd(0, v); chk("R10 ctrl readback", 32'(v), 32'h0037);
    wait_go_low();
    exp_mem[7] = sample(7, seed);
    check_data("R10 mode 11 pass");
    chk("R7 dma after route 1", 32'(dma_req), 1);
    dma_ack = 1'b1; @(negedge clk); dma_ack = 1'b0;
    wr(0, 16'h0000);

    // R3 scan repeats, R4 abort mid-pass
    seed = 9;
    wr(2, REG_W'((3 << 8) | 1));
    base = start_cnt;
    wr(0, 16'h0005);
    for (int k = 0; k < 500 && !irq; k++) @(negedge clk);
    chk("R3 first pass irq", 32'(irq), 1);
    rd(0, v); chk("R3 go stays 1", 32'(v[0]), 1);
    wr(1, 16'h0001);
    for (int k = 0; k < 500 && !irq; k++) @(negedge clk);
    chk("R3 second pass irq", 32'(irq), 1);
    chk("R3 strobes over two passes", 32'(start_cnt - base >= 6), 1);
    wr(1, 16'h0001);
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (conv_start && conv_ch == 3'd2) break;
    end
    wr(0, 16'h0004);
    base = start_cnt;
    repeat (30) @(negedge clk);
    chk("R4 no strobe after abort", 32'(start_cnt - base), 0);
    chk("R4 no irq for aborted pass", 32'(irq), 0);
    for (int c = 1; c <= 3; c++) exp_mem[c] = sample(c, seed);
    check_data("R4 in-flight result stored");

    // R4 abort in single mode
    seed = 11;
    wr(2, REG_W'((7 << 8) | 0));
    base = start_cnt;
    wr(0, 16'h0001);
    for (int k = 0; k < 500 && (start_cnt - base) < 2; k++) @(negedge clk);
    wr(0, 16'h0000);
    repeat (30) @(negedge clk);
    chk("R4 single abort strobes", 32'(start_cnt - base), 2);
    chk("R4 single abort irq", 32'(irq), 0);
    chk("R4 single abort dma", 32'(dma_req), 0);
    rd(0, v); chk("R4 go low", 32'(v[0]), 0);
    exp_mem[0] = sample(0, seed); exp_mem[1] = sample(1, seed);

    // R5 standby
    wr(2, REG_W'((1 << 8) | 0));
    wr(0, 16'h0005);
    repeat (20) @(negedge clk);
    standby_req = 1'b1; @(negedge clk); standby_req = 1'b0;
    rd(0, v); chk("R5 go cleared", 32'(v[0]), 0);
    repeat (12) @(negedge clk);
    base = start_cnt;
    repeat (30) @(negedge clk);
    chk("R5 no strobes after standby", 32'(start_cnt - base), 0);
    wr(1, 16'h0001);

    // R8 disabled trigger codes
    for (int code = 0; code < 3; code++) begin
      base = start_cnt;
      wr(0, REG_W'(code << 4));
      pulse_trg();
      repeat (20) @(negedge clk);
      chk("R8 disabled code no start", 32'(start_cnt - base), 0);
    end
    // R8 enabled trigger
    seed = 13;
    base = start_cnt;
    wr(0, 16'h0030);
    pulse_trg();
    wait_go_low();
    chk("R8 trigger pass strobes", 32'(start_cnt - base), 2);
    chk("R8 trigger pass irq", 32'(irq), 1);
    wr(1, 16'h0001);

    // R9 trigger while busy
    wr(2, REG_W'((7 << 8) | 0));
    base = start_cnt;
    wr(0, 16'h0031);
    repeat (10) @(negedge clk);
    pulse_trg();
    wait_go_low();
    repeat (30) @(negedge clk);
    chk("R9 one pass only", 32'(start_cnt - base), 8);
    rd(0, v); chk("R9 go low", 32'(v[0]), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule